// File: doc/BRIEF.md
# Address-Generation Interlock Detector

This block sits between the decode stage and the address-generation (AG) stage of an in-order pipeline whose register writes happen in the last stage, called put-away (PA). Each instruction in flight carries a write tag: a bit saying whether it writes a general-purpose register, and the 4-bit number of that register. The block keeps these tags in a shift chain from AG to PA. It compares the base and index fields of the instruction in decode against every tag from AG up to the stage just before PA. A match on a used field, other than register 0, raises `stall`. While `stall` is high, fetch and decode must hold, and AG receives a bubble.

The PA stage is left out of the comparison. The register file forwards a value being written to a read of the same register in the same cycle, so a dependent instruction may read while its producer is in PA. The block also forms the effective address as base value plus index value plus displacement. A register field of 0, or a field marked unused, contributes zero. With the default depth of four stages from AG to PA, a dependency on the instruction directly ahead costs three stall cycles.

Top module: `agi_interlock`

## Requirements
- R1: After reset, every write tag is cleared. `stall`, `ag_valid`, `ag_wr_en` and `pa_wr_en` are 0 until new instructions are issued.
- R2: `stall` is 1 while decode holds a valid instruction whose base field is marked used and is nonzero, and some tag in the AG stage or in a later stage short of PA has its write bit set with a destination equal to that base field.
- R3: The rule of R2 applies in the same way to the index field and its use flag.
- R4: A field whose use flag is 0 never raises `stall`, even when its value matches a pending write. A tag whose write bit is 0 never raises `stall` either.
- R5: A base or index field equal to register 0 never raises `stall`.
- R6: A writer that has reached PA raises no stall. An instruction issued four or more slots after its producer issues without waiting.
- R7: With `STAGES`=4, a dependent instruction stalls 3 cycles when it directly follows its producer, 2 cycles with one instruction between them, and 1 cycle with two between them.
- R8: At each clock edge where `stall` is 1, AG is loaded with a bubble, so `ag_valid` and `ag_wr_en` read 0 after that edge. Tags already in later stages keep advancing during a stall.
- R9: At the edge where a valid instruction issues (`stall` is 0), `ag_addr` is loaded with the base value plus the index value plus the zero-extended displacement, modulo 2^`ADDR_W`, and `ag_valid` becomes 1.
- R10: A base or index operand contributes zero to `ag_addr` when its field is 0 or its use flag is 0, whatever value is presented on its value input.
- R11: The write tag of an instruction issued at edge t appears on `ag_wr_en`/`ag_wr_reg` after edge t. It appears on `pa_wr_en`/`pa_wr_reg` after edge t+STAGES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d_valid | input | 1 | Decode holds a valid instruction |
| d_base | input | 4 | Base register field in decode |
| d_index | input | 4 | Index register field in decode |
| d_use_base | input | 1 | Base field is used by the instruction |
| d_use_index | input | 1 | Index field is used by the instruction |
| d_wr_en | input | 1 | Instruction writes a register at PA |
| d_wr_reg | input | 4 | Register the instruction writes |
| d_disp | input | DISP_W | Displacement, zero-extended |
| base_val | input | ADDR_W | Register file value read for the base field |
| index_val | input | ADDR_W | Register file value read for the index field |
| stall | output | 1 | Hold fetch and decode; bubble into AG |
| ag_valid | output | 1 | AG holds a real instruction |
| ag_addr | output | ADDR_W | Effective address formed in AG |
| ag_wr_en | output | 1 | Write bit of the AG tag |
| ag_wr_reg | output | 4 | Destination of the AG tag |
| pa_wr_en | output | 1 | Write bit of the PA tag (register file write enable) |
| pa_wr_reg | output | 4 | Destination of the PA tag |

## Verification
The bench counts stall cycles for dependency distances of zero through three intervening instructions. This catches a design that includes PA in the compare, which would add one cycle everywhere, and one that drops a stage from the compare, which would release the stall a cycle early. It pairs matching register numbers with a cleared use flag, a cleared write bit and register 0. A design that ignores any of these qualifiers stalls where the expected count is zero. It also checks that no bubble carries a write bit, that a producer still reaches PA on schedule while decode is held, and that the adder wraps and zeroes register 0 and unused operands.

// File: rtl/agi_pkg.sv
package agi_pkg;
  parameter int REG_W = 4;
  localparam int NUM_REGS = 1 << REG_W;

  typedef struct packed {
    logic             we;
    logic [REG_W-1:0] rd;
  } wtag_t;
endpackage

// File: rtl/agi_tag_pipe.sv
module agi_tag_pipe
  import agi_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  wtag_t               in_tag,
  output wtag_t [STAGES-1:0]  tags
);
  wtag_t [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q[0] <= '0;
    end else begin
      q[0].we <= load & in_tag.we;
      q[0].rd <= in_tag.rd;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (rst) q[i] <= '0;
      else     q[i] <= q[i-1];
    end

    // R8/R11: later stages advance every cycle, stall or not
    a_r11_shift: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> q[i] == $past(q[i-1]));
  end

  assign tags = q;

  // R8: a bubble loaded into the first stage never carries a write bit
  a_r8_bubble_no_write: assert property (@(posedge clk) disable iff (rst)
    !load |=> !q[0].we);
endmodule

// File: rtl/agi_hazard.sv
module agi_hazard
  import agi_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                     d_valid,
  input  logic [REG_W-1:0]         d_base,
  input  logic [REG_W-1:0]         d_index,
  input  logic                     d_use_base,
  input  logic                     d_use_index,
  input  wtag_t [STAGES-1:0]       tags,
  output logic                     stall
);
  // PA (last index) is covered by the register file bypass
  localparam int CHK = STAGES - 1;

  logic need_b, need_x;
  logic [CHK-1:0] hit;

  assign need_b = d_use_base  && (d_base  != '0);
  assign need_x = d_use_index && (d_index != '0);

  for (genvar i = 0; i < CHK; i++) begin : g_cmp
    assign hit[i] = tags[i].we &&
                    ((need_b && tags[i].rd == d_base) ||
                     (need_x && tags[i].rd == d_index));
  end

  assign stall = d_valid && (|hit);

  // R4/R5: a stall always traces back to a used, nonzero field
  always_comb begin
    if (stall)
      a_r5_nonzero_field: assert ((d_use_base && d_base != '0) ||
                                  (d_use_index && d_index != '0));
  end
endmodule

// File: rtl/agi_addr_gen.sv
module agi_addr_gen
  import agi_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [REG_W-1:0]    base_f,
  input  logic [REG_W-1:0]    index_f,
  input  logic                use_b,
  input  logic                use_x,
  input  logic [DISP_W-1:0]   disp,
  input  logic [ADDR_W-1:0]   base_val,
  input  logic [ADDR_W-1:0]   index_val,
  output logic                ag_valid,
  output logic [ADDR_W-1:0]   ag_addr
);
  logic [ADDR_W-1:0] op_b, op_x, op_d;

  assign op_b = (use_b && base_f  != '0) ? base_val  : '0;
  assign op_x = (use_x && index_f != '0) ? index_val : '0;
  assign op_d = ADDR_W'(disp);

  always_ff @(posedge clk) begin
    if (rst) begin
      ag_valid <= 1'b0;
      ag_addr  <= '0;
    end else begin
      ag_valid <= load;
      if (load) ag_addr <= op_b + op_x + op_d;
    end
  end

  // R9: address holds while no instruction issues
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ag_addr));
endmodule

// File: rtl/agi_interlock.sv
module agi_interlock
  import agi_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int ADDR_W = 24,
  parameter int DISP_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               d_valid,
  input  logic [REG_W-1:0]   d_base,
  input  logic [REG_W-1:0]   d_index,
  input  logic               d_use_base,
  input  logic               d_use_index,
  input  logic               d_wr_en,
  input  logic [REG_W-1:0]   d_wr_reg,
  input  logic [DISP_W-1:0]  d_disp,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [ADDR_W-1:0]  index_val,
  output logic               stall,
  output logic               ag_valid,
  output logic [ADDR_W-1:0]  ag_addr,
  output logic               ag_wr_en,
  output logic [REG_W-1:0]   ag_wr_reg,
  output logic               pa_wr_en,
  output logic [REG_W-1:0]   pa_wr_reg
);
  localparam int RUN_W = $clog2(STAGES) + 1;

  wtag_t [STAGES-1:0] tags;
  wtag_t              dec_tag;
  logic               issue;

  assign dec_tag.we = d_wr_en;
  assign dec_tag.rd = d_wr_reg;
  assign issue      = d_valid && !stall;

  agi_hazard #(.STAGES(STAGES)) u_haz (
    .d_valid     (d_valid),
    .d_base      (d_base),
    .d_index     (d_index),
    .d_use_base  (d_use_base),
    .d_use_index (d_use_index),
    .tags        (tags),
    .stall       (stall)
  );

  agi_tag_pipe #(.STAGES(STAGES)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .load   (issue),
    .in_tag (dec_tag),
    .tags   (tags)
  );

  agi_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .clk       (clk),
    .rst       (rst),
    .load      (issue),
    .base_f    (d_base),
    .index_f   (d_index),
    .use_b     (d_use_base),
    .use_x     (d_use_index),
    .disp      (d_disp),
    .base_val  (base_val),
    .index_val (index_val),
    .ag_valid  (ag_valid),
    .ag_addr   (ag_addr)
  );

  assign ag_wr_en  = tags[0].we;
  assign ag_wr_reg = tags[0].rd;
  assign pa_wr_en  = tags[STAGES-1].we;
  assign pa_wr_reg = tags[STAGES-1].rd;

  // Consecutive stall cycles, for the R7 bound
  logic [RUN_W-1:0] run;
  always_ff @(posedge clk) begin
    if (rst)        run <= '0;
    else if (stall) run <= run + 1'b1;
    else            run <= '0;
  end

  // R8: a stall edge leaves AG empty and without a write
  a_r8_bubble: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ag_valid && !ag_wr_en));

  // R7: with decode held, no stall outlasts the compared stages
  a_r7_run_bound: assert property (@(posedge clk) disable iff (rst)
    run < RUN_W'(STAGES));

  // R1: first cycle out of reset has no pending writes
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!pa_wr_en && !ag_wr_en && !ag_valid));
endmodule

// File: tb/agi_interlock_test.sv
module agi_interlock_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 4;
  localparam int ADDR_W = 24;
  localparam int DISP_W = 12;

  logic clk = 1'b0;
  logic rst;
  logic d_valid, d_use_base, d_use_index, d_wr_en;
  logic [3:0] d_base, d_index, d_wr_reg;
  logic [DISP_W-1:0] d_disp;
  logic [ADDR_W-1:0] base_val, index_val;
  logic stall, ag_valid, ag_wr_en, pa_wr_en;
  logic [ADDR_W-1:0] ag_addr;
  logic [3:0] ag_wr_reg, pa_wr_reg;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agi_interlock #(.STAGES(STAGES), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) uut (
    .clk(clk), .rst(rst), .d_valid(d_valid), .d_base(d_base), .d_index(d_index),
    .d_use_base(d_use_base), .d_use_index(d_use_index), .d_wr_en(d_wr_en),
    .d_wr_reg(d_wr_reg), .d_disp(d_disp), .base_val(base_val), .index_val(index_val),
    .stall(stall), .ag_valid(ag_valid), .ag_addr(ag_addr), .ag_wr_en(ag_wr_en),
    .ag_wr_reg(ag_wr_reg), .pa_wr_en(pa_wr_en), .pa_wr_reg(pa_wr_reg)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Presents one instruction in decode, holds it through any stall,
  // and returns the number of stall cycles; bubbles checked per edge (R8).
  task automatic issue(input logic ub, input logic [3:0] b, input logic ux,
                       input logic [3:0] x, input logic we, input logic [3:0] wr,
                       input logic [DISP_W-1:0] disp, input logic [ADDR_W-1:0] bv,
                       input logic [ADDR_W-1:0] xv, output int stalls);
    logic s;
    @(negedge clk);
    d_valid = 1'b1; d_use_base = ub; d_base = b; d_use_index = ux; d_index = x;
    d_wr_en = we; d_wr_reg = wr; d_disp = disp; base_val = bv; index_val = xv;
    stalls = 0;
    #1 s = stall;
    while (1) begin
      @(posedge clk);
      #1;
      if (!s) break;
      stalls++;
      check(!ag_valid && !ag_wr_en, "R8 bubble", {ag_valid, ag_wr_en}, 0);
      s = stall;
    end
    d_valid = 1'b0; d_wr_en = 1'b0; d_use_base = 1'b0; d_use_index = 1'b0;
  endtask

  task automatic idle(input int n);
    d_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writer(input logic [3:0] r);
    int s;
    issue(1'b0, 4'd0, 1'b0, 4'd0, 1'b1, r, '0, '0, '0, s);
  endtask

  task automatic filler();
    int s;
    issue(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, '0, '0, '0, s);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    d_valid = 0; d_use_base = 0; d_use_index = 0; d_wr_en = 0;
    d_base = 0; d_index = 0; d_wr_reg = 0; d_disp = 0; base_val = 0; index_val = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check(!stall && !ag_valid && !ag_wr_en && !pa_wr_en, "R1 reset state",
          {stall, ag_valid, ag_wr_en, pa_wr_en}, 0);
  endtask

  task automatic t_distance(input int gap, input bit use_idx, input int exp, input string req);
    int s;
    writer(4'd5);
    for (int k = 0; k < gap; k++) filler();
    if (use_idx) issue(1'b0, 4'd0, 1'b1, 4'd5, 1'b0, 4'd0, '0, '0, '0, s);
    else         issue(1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 4'd0, '0, '0, '0, s);
    check(s == exp, req, s, exp);
    idle(STAGES + 1);
  endtask

  task automatic t_qualifiers();
    int s;
    // R4: matching base, use flag clear
    writer(4'd7);
    issue(1'b0, 4'd7, 1'b0, 4'd7, 1'b0, 4'd0, '0, '0, '0, s);
    check(s == 0, "R4 unused field", s, 0);
    idle(STAGES + 1);
    // R4: matching register, write bit clear
    issue(1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd7, '0, '0, '0, s);
    issue(1'b1, 4'd7, 1'b0, 4'd0, 1'b0, 4'd0, '0, '0, '0, s);
    check(s == 0, "R4 no-write tag", s, 0);
    idle(STAGES + 1);
    // R5: register 0 as base and index
    writer(4'd0);
    issue(1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, '0, '0, '0, s);
    check(s == 0, "R5 register zero", s, 0);
    idle(STAGES + 1);
  endtask

  task automatic t_addr();
    int s;
    issue(1'b1, 4'd3, 1'b1, 4'd4, 1'b0, 4'd0, 12'h123, 24'h001000, 24'h000020, s);
    check(ag_valid && ag_addr == 24'h001143, "R9 address sum", ag_addr, 24'h001143);
    issue(1'b1, 4'd3, 1'b1, 4'd4, 1'b0, 4'd0, 12'hFFF, 24'hFFFFF0, 24'h000020, s);
    check(ag_addr == 24'h00100F, "R9 address wrap", ag_addr, 24'h00100F);
    issue(1'b1, 4'd0, 1'b1, 4'd4, 1'b0, 4'd0, 12'h010, 24'h555555, 24'h000100, s);
    check(ag_addr == 24'h000110, "R10 base reg0 zero", ag_addr, 24'h000110);
    issue(1'b1, 4'd2, 1'b0, 4'd4, 1'b0, 4'd0, 12'h001, 24'h000200, 24'h777777, s);
    check(ag_addr == 24'h000201, "R10 unused index zero", ag_addr, 24'h000201);
    idle(2);
    check(!ag_valid, "R9 valid drops when idle", ag_valid, 0);
  endtask

  task automatic t_tag_timing();
    int s;
    writer(4'd9);
    check(ag_wr_en && ag_wr_reg == 4'd9, "R11 tag in AG", ag_wr_reg, 9);
    idle(STAGES - 2);
    check(!pa_wr_en, "R11 not yet at PA", pa_wr_en, 0);
    idle(1);
    check(pa_wr_en && pa_wr_reg == 4'd9, "R11 tag at PA", pa_wr_reg, 9);
    idle(STAGES + 1);
    // R8: producer still reaches PA while the consumer is held
    writer(4'd11);
    @(negedge clk);
    d_valid = 1'b1; d_use_base = 1'b1; d_base = 4'd11; d_use_index = 1'b0;
    d_wr_en = 1'b0;
    #1 check(stall, "R2 stall raised", stall, 1);
    repeat (STAGES - 1) @(posedge clk);
    #1;
    check(pa_wr_en && pa_wr_reg == 4'd11, "R8 later stages advance", pa_wr_reg, 11);
    check(!stall, "R6 PA writer releases stall", stall, 0);
    @(posedge clk);
    #1 d_valid = 1'b0; d_use_base = 1'b0;
    idle(STAGES + 1);
  endtask

  initial begin
    t_reset();
    t_distance(0, 1'b0, 3, "R7 back-to-back base stalls 3 (R2)");
    t_distance(0, 1'b1, 3, "R7 back-to-back index stalls 3 (R3)");
    t_distance(1, 1'b0, 2, "R7 gap one stalls 2");
    t_distance(2, 1'b1, 1, "R7 gap two stalls 1");
    t_distance(3, 1'b0, 0, "R6 gap three no stall");
    t_qualifiers();
    t_addr();
    t_tag_timing();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule